// File: doc/BRIEF.md
# Single-Precision Compare Unit with Condition Flags

This block takes two single-precision operands and decides how they are ordered. The answer is a four-bit one-hot condition field with one bit each for less, equal, greater and unordered. The block also has an invalid-operation path. Any operand value below the normal range is treated as zero before the comparison. A signalling NaN is handled in one of two ways, chosen by an enable input. With the enable clear, the result is simply unordered. With the enable set, an invalid cause bit is raised, no condition bit is set, and a trap request goes out.

Operands arrive on a valid/ready stream. The result leaves on a second valid/ready stream. An accepted request gives its result on the next cycle. The result register holds one compare. It stays valid and unchanged until the consumer takes it. While a result waits, input ready is low, so a new request is accepted only when the output is empty or is being taken in that same cycle. Every accepted compare writes all of the result fields, so nothing from an earlier compare carries over.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, out_valid, cc_flags, inv_cause and trap_req are all 0.
- R2: A request taken when in_valid and in_ready are both high on a clock edge produces out_valid high after that edge. Whenever inv_cause is 0, exactly one bit of cc_flags is set.
- R3: While out_valid is 1 and out_ready is 0, in_ready is 0, and cc_flags and inv_cause keep their values. A request offered during that time is not taken.
- R4: The bits of cc_flags are assigned as follows: bit 0 is less (a<b), bit 1 is equal, bit 2 is greater (a>b), bit 3 is unordered. Ordered operands, including infinities of either sign, set the matching bit. Two infinities of the same sign compare equal.
- R5: An operand whose exponent field is zero is treated as zero, whatever its fraction and sign. So +0, -0 and any subnormal compare equal to each other.
- R6: A quiet NaN operand (exponent all ones, fraction MSB 1) gives unordered with inv_cause 0, whatever the value of v_enable.
- R7: A signalling NaN operand (exponent all ones, fraction MSB 0, fraction nonzero) with v_enable 0 gives unordered with inv_cause 0.
- R8: A signalling NaN in either operand with v_enable 1 gives inv_cause 1 and cc_flags 0, even when the other operand is a quiet NaN.
- R9: trap_req is 1 exactly when a valid result has inv_cause set.
- R10: Each accepted compare replaces both the condition field and the cause bit. A compare that follows a trapping compare shows inv_cause 0 and only its own condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | The unit can take an operand pair this cycle |
| op_a | input | 32 | First operand, single-precision |
| op_b | input | 32 | Second operand, single-precision |
| v_enable | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result is held and valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| cc_flags | output | 4 | One-hot condition: [0] less, [1] equal, [2] greater, [3] unordered |
| inv_cause | output | 1 | Invalid-operation cause |
| trap_req | output | 1 | Trap request for the held result |

## Verification
The bench targets the corner cases that are easy to get wrong:
- Two negative operands have a reversed magnitude order. A design that compares raw bits would report greater for -2 against -1.
- A negative subnormal compared with +0 must give equal. A design that skips the flush would report less.
- A signalling NaN paired with a quiet NaN must still raise the cause. A design that checks for quiet NaNs first would quietly return unordered.
- Under back-pressure, a second request is offered while the result waits. A design that takes it would overwrite the held flags.
- A clean compare follows a trapping one. A design that ORs the cause into its old value would leave the trap request stuck high.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int unsigned CC_W  = 4;
  localparam int unsigned CC_LT = 0;
  localparam int unsigned CC_EQ = 1;
  localparam int unsigned CC_GT = 2;
  localparam int unsigned CC_UN = 3;

  typedef enum logic [1:0] {
    CLS_FINITE = 2'd0,
    CLS_INF    = 2'd1,
    CLS_QNAN   = 2'd2,
    CLS_SNAN   = 2'd3
  } opnd_cls_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W  = EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word,
  output opnd_cls_e         cls,
  output logic              sign_eff,
  output logic [MAG_W-1:0]  mag
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic             exp_zero;
  logic             exp_ones;

  assign expo     = word[WORD_W-2 -: EXP_W];
  assign frac     = word[MAN_W-1:0];
  assign exp_zero = (expo == '0);
  assign exp_ones = (expo == '1);

  always_comb begin
    if (!exp_ones)          cls = CLS_FINITE;
    else if (frac == '0)    cls = CLS_INF;
    else if (frac[MAN_W-1]) cls = CLS_QNAN;
    else                    cls = CLS_SNAN;
  end

  // flush: anything with a zero exponent becomes an unsigned zero
  assign mag      = exp_zero ? '0 : word[MAG_W-1:0];
  assign sign_eff = exp_zero ? 1'b0 : word[WORD_W-1];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int unsigned MAG_W = 31
) (
  input  opnd_cls_e        cls_a,
  input  opnd_cls_e        cls_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             v_enable,
  output logic [CC_W-1:0]  cc,
  output logic             cause
);
  logic any_snan;
  logic any_qnan;
  logic mag_lt;
  logic mag_eq;
  logic a_below;
  logic same_val;

  assign any_snan = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  assign any_qnan = (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);
  assign mag_lt   = (mag_a < mag_b);
  assign mag_eq   = (mag_a == mag_b);
  assign same_val = mag_eq && (sign_a == sign_b);

  always_comb begin
    if (sign_a != sign_b) a_below = sign_a;
    else if (sign_a)      a_below = !mag_lt && !mag_eq;
    else                  a_below = mag_lt;
  end

  always_comb begin
    cc    = '0;
    cause = 1'b0;
    if (any_snan) begin
      if (v_enable) cause = 1'b1;
      else          cc[CC_UN] = 1'b1;
    end else if (any_qnan) begin
      cc[CC_UN] = 1'b1;
    end else if (same_val) begin
      cc[CC_EQ] = 1'b1;
    end else if (a_below) begin
      cc[CC_LT] = 1'b1;
    end else begin
      cc[CC_GT] = 1'b1;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W  = EXP_W + MAN_W,
  localparam int unsigned N_OPND = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              v_enable,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CC_W-1:0]   cc_flags,
  output logic              inv_cause,
  output logic              trap_req
);
  logic [N_OPND-1:0][WORD_W-1:0] words;
  opnd_cls_e                     cls   [N_OPND];
  logic [N_OPND-1:0]             sgn;
  logic [N_OPND-1:0][MAG_W-1:0]  mag;
  logic [CC_W-1:0]               cc_next;
  logic                          cause_next;
  logic                          take;

  assign words[0] = op_a;
  assign words[1] = op_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word    (words[gi]),
      .cls     (cls[gi]),
      .sign_eff(sgn[gi]),
      .mag     (mag[gi])
    );
  end

  fpcmp_order #(.MAG_W(MAG_W)) u_ord (
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .sign_a  (sgn[0]),
    .sign_b  (sgn[1]),
    .mag_a   (mag[0]),
    .mag_b   (mag[1]),
    .v_enable(v_enable),
    .cc      (cc_next),
    .cause   (cause_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cc_flags  <= '0;
      inv_cause <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      cc_flags  <= cc_next;
      inv_cause <= cause_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign trap_req = out_valid && inv_cause;
endmodule

// File: rtl/fpcmp_unit_checker.sv
module fpcmp_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] cc_flags,
  input logic       inv_cause,
  input logic       trap_req
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !inv_cause |-> $countones(cc_flags) == 1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cc_flags) && $stable(inv_cause));

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_nocc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && inv_cause |-> cc_flags == 4'b0000);

  p_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> out_valid && inv_cause);
endmodule

bind fpcmp_unit fpcmp_unit_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .cc_flags (cc_flags),
  .inv_cause(inv_cause),
  .trap_req (trap_req)
);

// File: tb/fpcmp_unit_bench.sv
module fpcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        v_enable = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  cc_flags;
  logic        inv_cause;
  logic        trap_req;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] LT = 4'b0001, EQ = 4'b0010, GT = 4'b0100, UN = 4'b1000;
  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PDN = 32'h0000_0001, NDN = 32'h8000_0001;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;

  always #5 clk = ~clk;

  fpcmp_unit u_fpcmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .v_enable(v_enable), .out_valid(out_valid),
    .out_ready(out_ready), .cc_flags(cc_flags), .inv_cause(inv_cause),
    .trap_req(trap_req)
  );

  task automatic expect_out(input string req, input logic vld, input logic [3:0] cc,
                            input logic cause, input logic trap);
    n_chk++;
    if (out_valid !== vld || cc_flags !== cc || inv_cause !== cause || trap_req !== trap) begin
      n_bad++;
      $display("FAIL %s: got valid=%b cc=%b cause=%b trap=%b, want valid=%b cc=%b cause=%b trap=%b",
               req, out_valid, cc_flags, inv_cause, trap_req, vld, cc, cause, trap);
    end
  endtask

  // one compare with out_ready high; result sampled at the negedge after the accepting edge
  task automatic run_cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic ven, input logic [3:0] cc, input logic cause);
    @(negedge clk);
    op_a = a; op_b = b; v_enable = ven; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(req, 1'b1, cc, cause, cause);
  endtask

  task automatic t_reset;
    expect_out("R1", 1'b0, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_order;
    run_cmp("R4 1<2", P1, P2, 1'b0, LT, 1'b0);
    run_cmp("R4 2>1", P2, P1, 1'b0, GT, 1'b0);
    run_cmp("R4 -1<1", N1, P1, 1'b0, LT, 1'b0);
    run_cmp("R4 -2<-1", N2, N1, 1'b0, LT, 1'b0);
    run_cmp("R4 -1>-2", N1, N2, 1'b0, GT, 1'b0);
    run_cmp("R2 1==1", P1, P1, 1'b1, EQ, 1'b0);
    run_cmp("R4 +inf>2", PINF, P2, 1'b0, GT, 1'b0);
    run_cmp("R4 -inf<-2", NINF, N2, 1'b0, LT, 1'b0);
    run_cmp("R4 inf==inf", PINF, PINF, 1'b0, EQ, 1'b0);
    run_cmp("R4 -inf<+inf", NINF, PINF, 1'b0, LT, 1'b0);
  endtask

  task automatic t_zero_flush;
    run_cmp("R5 +0==-0", PZ, NZ, 1'b0, EQ, 1'b0);
    run_cmp("R5 sub==+0", PDN, PZ, 1'b0, EQ, 1'b0);
    run_cmp("R5 -sub==+0", NDN, PZ, 1'b0, EQ, 1'b0);
    run_cmp("R5 sub<1", PDN, P1, 1'b0, LT, 1'b0);
  endtask

  task automatic t_nans;
    run_cmp("R6 qnan,1", QN, P1, 1'b0, UN, 1'b0);
    run_cmp("R6 1,qnan en", P1, QN, 1'b1, UN, 1'b0);
    run_cmp("R7 snan dis", SN, P1, 1'b0, UN, 1'b0);
    run_cmp("R8 snan en", P1, SN, 1'b1, 4'b0000, 1'b1);
    run_cmp("R8 qnan+snan en", QN, SN, 1'b1, 4'b0000, 1'b1);
    run_cmp("R10 after trap", P1, P2, 1'b1, LT, 1'b0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    op_a = P2; op_b = P1; v_enable = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    op_a = P1; op_b = P2;               // second request held off
    for (int i = 0; i < 3; i++) begin
      n_chk++;
      if (in_ready !== 1'b0) begin
        n_bad++;
        $display("FAIL R3: got in_ready=%b want 0", in_ready);
      end
      expect_out("R3 hold", 1'b1, GT, 1'b0, 1'b0);
      @(negedge clk);
    end
    out_ready = 1'b1;                   // drain and accept together
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R3 next", 1'b1, LT, 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R2 drained", 1'b0, LT, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_zero_flush();
    t_nans();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule